// File: doc/BRIEF.md
# Wake-Pin Event Detector

This block monitors a row of external wake-up pins and an internal wake line, and produces the request that pulls a device out of Standby or Shutdown. The pins have seven slots. Slots 0 to 4 and slot 6 are implemented. Slot 5 is a hole and always reads zero. Every implemented pin has an enable and a polarity bit, and the polarity bit picks the edge that counts as an event. Before edge detection, each pin passes through a two-flop synchroniser, because the pins are asynchronous to the block clock.

An event on an enabled pin sets that pin's sticky flag. The flag stays set until software writes a 1 to the matching bit of a separate clear port, presented together with a write strobe. The internal wake flag works differently. It follows the OR of the internal sources, gated by its own enable, so it drops by itself once every source has gone away. The wake request is the OR of all pin flags and the internal flag. Register decoding and power sequencing are the job of the surrounding logic.

Top module: `wake_pin_detect`

## Requirements
- R1: While reset is asserted, every pin flag, the internal flag and the wake request read 0.
- R2: Pin slots 0 to 4 and 6 are implemented. The flag at bit 5 reads 0 whatever its pin, enable or polarity inputs do.
- R3: On an enabled pin, polarity 0 makes a rising edge an event and polarity 1 makes a falling edge an event. The opposite edge sets nothing.
- R4: A pin event sets its flag on the third rising clock edge after the pin changes: two synchroniser stages, then the edge register.
- R5: A disabled pin never sets its flag. Enabling a pin that is held steady at its active level creates no event.
- R6: Changing a pin's polarity while the pin level is steady creates no event.
- R7: A set pin flag stays set until a clock edge on which the clear strobe is high and the matching clear-mask bit is 1. Mask bits that are 0, and mask values presented without the strobe, leave the flags unchanged.
- R8: If a clear and a new event hit the same flag on the same edge, the flag ends up set.
- R9: The internal flag is 1 one clock after the internal enable is high and at least one internal source is high. It is 0 one clock after the enable is low or all sources are low.
- R10: The wake request is the combinational OR of all pin flags and the internal flag.
- R11: For the first three clock edges after reset is released, no events are taken. A pin already at its active level during reset therefore sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 7 | Raw wake pins, asynchronous |
| pin_en_i | input | 7 | Per-pin enable |
| pin_pol_i | input | 7 | Per-pin edge select, 0 rising, 1 falling |
| clr_wr_i | input | 1 | Clear strobe |
| clr_mask_i | input | 7 | Write-one-to-clear mask, used when the strobe is high |
| int_src_i | input | 3 | Internal wake sources, synchronous |
| int_en_i | input | 1 | Internal wake line enable |
| pin_flag_o | output | 7 | Sticky pin flags |
| int_flag_o | output | 1 | Internal wake flag |
| wake_req_o | output | 1 | Wake request |

## Verification
A pin change driven just after a falling clock edge is due in its flag after the third following rising edge. A clear or an internal-source change is due after the first rising edge. The wake request is due in the same cycle as the flags it combines. The bench drives every input at the falling edge and advances one rising edge per step. Its reference model ages a pin sample through the same three-edge history, applies clears and internal changes at a single edge, and compares all outputs at the next falling edge. The latency cases also check the flag explicitly as still clear after the first and second edges and set after the third.

// File: rtl/wake_pin_detect.sv
module wake_pin_detect #(
  parameter int                   NUM_SLOTS   = 7,
  parameter logic [NUM_SLOTS-1:0] IMPL_MASK   = 7'b101_1111,
  parameter int                   NUM_INT     = 3,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] pin_i,
  input  logic [NUM_SLOTS-1:0] pin_en_i,
  input  logic [NUM_SLOTS-1:0] pin_pol_i,
  input  logic                 clr_wr_i,
  input  logic [NUM_SLOTS-1:0] clr_mask_i,
  input  logic [NUM_INT-1:0]   int_src_i,
  input  logic                 int_en_i,
  output logic [NUM_SLOTS-1:0] pin_flag_o,
  output logic                 int_flag_o,
  output logic                 wake_req_o
);

  localparam int                 PRIME_W    = $clog2(SYNC_STAGES + 2);
  localparam logic [PRIME_W-1:0] PRIME_DONE = PRIME_W'(SYNC_STAGES + 1);

  logic [NUM_SLOTS-1:0] sync_q [SYNC_STAGES];
  logic [NUM_SLOTS-1:0] prev_q;
  logic [NUM_SLOTS-1:0] flag_q;
  logic [PRIME_W-1:0]   prime_q;
  logic                 int_q;

  logic [NUM_SLOTS-1:0] lvl, rise, fall, evt, clr_vec;
  logic                 armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prime_q <= '0;
    else if (!armed)  prime_q <= prime_q + 1'b1;
  end

  assign lvl     = sync_q[SYNC_STAGES-1];
  assign armed   = (prime_q == PRIME_DONE);
  assign rise    = lvl & ~prev_q;
  assign fall    = ~lvl & prev_q;
  assign evt     = armed ? (((rise & ~pin_pol_i) | (fall & pin_pol_i)) & pin_en_i & IMPL_MASK) : '0;
  assign clr_vec = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      int_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | evt;
      int_q  <= int_en_i & (|int_src_i);
    end
  end

  assign pin_flag_o = flag_q;
  assign int_flag_o = int_q;
  assign wake_req_o = (|flag_q) | int_q;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_flag_o & $past(clr_vec & ~evt)) == '0)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pin_flag_o & $past(pin_flag_o & ~clr_vec)) == '0)); // R7

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_flag_o & ~$past(pin_flag_o) & ~$past(pin_en_i)) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pin_flag_o & $past(evt)) == '0)); // R8

  AST_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en_i && (|int_src_i)) |=> int_flag_o); // R9

  AST_INT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en_i || (int_src_i == '0)) |=> !int_flag_o); // R9

endmodule

// File: tb/wake_pin_detect_tb.sv
module wake_pin_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] IMPL = 7'b101_1111;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] pin, en, pol, clr_data;
  logic       clr_wr, int_en;
  logic [2:0] src;
  logic [6:0] flag_o;
  logic       int_o, wake_o;

  int ncmp = 0;
  int nbad = 0;

  logic [6:0] m_s1, m_s2, m_pv, m_flag;
  logic       m_int;
  int         m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_pin_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_en_i(en), .pin_pol_i(pol),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_data), .int_src_i(src), .int_en_i(int_en),
    .pin_flag_o(flag_o), .int_flag_o(int_o), .wake_req_o(wake_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] model_evt(input logic [6:0] prv, input logic [6:0] cur,
                                           input logic [6:0] p, input logic [6:0] e);
    return (((cur & ~prv) & ~p) | ((~cur & prv) & p)) & e & IMPL;
  endfunction

  task automatic step(input string tag);
    logic [6:0] ev;
    @(posedge clk);
    ev     = (m_cnt == 3) ? model_evt(m_pv, m_s2, pol, en) : 7'h0;
    m_flag = (m_flag & ~(clr_wr ? clr_data : 7'h0)) | ev;
    m_pv   = m_s2;
    m_s2   = m_s1;
    m_s1   = pin;
    if (m_cnt < 3) m_cnt++;
    m_int  = int_en & (|src);
    @(negedge clk);
    chk({tag, " flags"}, 32'(flag_o), 32'(m_flag));
    chk({tag, " int"},   32'(int_o),  32'(m_int));
    chk({tag, " wake"},  32'(wake_o), 32'((|m_flag) | m_int));
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = 7'h7F;
    step("R7 clear-all");
    clr_wr = 1'b0; clr_data = 7'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pin = 7'h7F; en = 7'h7F; pol = 7'h00;
    clr_wr = 1'b0; clr_data = 7'h00; src = 3'b000; int_en = 1'b0;
    m_s1 = '0; m_s2 = '0; m_pv = '0; m_flag = '0; m_int = 1'b0; m_cnt = 0;
    src = 3'b111; int_en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 flags in reset", 32'(flag_o), 32'h0);
    chk("R1 int in reset",   32'(int_o),  32'h0);
    chk("R1 wake in reset",  32'(wake_o), 32'h0);
    src = 3'b000; int_en = 1'b0;
    rst_n = 1'b1;

    repeat (6) step("R11 priming");
    chk("R11 pin high at reset", 32'(flag_o), 32'h0);

    pin = 7'h00;
    repeat (4) step("R3 wrong edge");
    chk("R3 falling with pol0", 32'(flag_o), 32'h0);

    pin[0] = 1'b1;
    step("R4 latency"); chk("R4 edge1", 32'(flag_o[0]), 32'h0);
    step("R4 latency"); chk("R4 edge2", 32'(flag_o[0]), 32'h0);
    step("R4 latency"); chk("R4 edge3", 32'(flag_o[0]), 32'h1);

    pol[1] = 1'b1; pin[1] = 1'b1;
    repeat (4) step("R3 rise pol1");
    chk("R3 rising with pol1", 32'(flag_o[1]), 32'h0);
    pin[1] = 1'b0;
    repeat (4) step("R3 fall pol1");
    chk("R3 falling with pol1", 32'(flag_o[1]), 32'h1);
    chk("R10 wake from flags", 32'(wake_o), 32'h1);

    for (int k = 0; k < 4; k++) begin
      pin[5] = ~pin[5]; pol[5] = k[0];
      repeat (4) step("R2 hole");
    end
    chk("R2 slot5 zero", 32'(flag_o[5]), 32'h0);

    clr_data = 7'h7F; clr_wr = 1'b0;
    repeat (2) step("R7 no strobe");
    chk("R7 mask without strobe", 32'(flag_o), 32'h03);
    clr_wr = 1'b1; clr_data = 7'h01;
    step("R7 partial");
    clr_wr = 1'b0; clr_data = 7'h00;
    chk("R7 partial clear", 32'(flag_o), 32'h02);
    clear_all();
    chk("R10 wake idle", 32'(wake_o), 32'h0);

    en = 7'h00; pol = 7'h00; pin[2] = 1'b1;
    repeat (4) step("R5 disabled");
    chk("R5 disabled pin", 32'(flag_o), 32'h0);
    en[2] = 1'b1;
    repeat (4) step("R5 enable steady");
    chk("R5 enable at active level", 32'(flag_o), 32'h0);

    en[3] = 1'b1; pin[3] = 1'b1;
    repeat (4) step("R3 pin3");
    chk("R3 pin3 rising", 32'(flag_o[3]), 32'h1);
    clear_all();
    for (int k = 0; k < 6; k++) begin
      pol[3] = ~pol[3]; pol[2] = ~pol[2];
      step("R6 polarity flip");
    end
    chk("R6 no false edge", 32'(flag_o), 32'h0);
    pol = 7'h00;
    repeat (3) step("R6 settle");

    en[4] = 1'b1; pin[4] = 1'b1;
    step("R8 pre"); step("R8 pre");
    clr_wr = 1'b1; clr_data = 7'h10;
    step("R8 collide");
    clr_wr = 1'b0; clr_data = 7'h00;
    chk("R8 set wins", 32'(flag_o[4]), 32'h1);
    clear_all();

    int_en = 1'b1; src = 3'b010;
    step("R9 set");
    chk("R9 int set", 32'(int_o), 32'h1);
    chk("R10 wake from int", 32'(wake_o), 32'h1);
    src = 3'b000;
    step("R9 drop");
    chk("R9 int drop", 32'(int_o), 32'h0);
    src = 3'b101; int_en = 1'b0;
    step("R9 gated");
    chk("R9 int gated", 32'(int_o), 32'h0);

    for (int n = 0; n < 3000; n++) begin
      pin = pin ^ (7'($urandom) & 7'($urandom) & 7'($urandom));
      if (($urandom % 16) == 0) en  = 7'($urandom);
      if (($urandom % 16) == 0) pol = 7'($urandom);
      clr_wr   = (($urandom % 8) == 0);
      clr_data = 7'($urandom);
      src      = 3'($urandom) & 3'($urandom);
      if (($urandom % 4) == 0) int_en = 1'($urandom);
      step("R3/R4/R7/R8/R9/R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule